// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It takes the raw line input and a single-cycle enable that pulses sixteen times per bit period. It passes the line through a short synchronizer and waits for a falling edge. It confirms the start bit half a bit later. It then samples each following bit at its centre and shifts in 7 or 8 data bits, least significant bit first. If parity is enabled, one parity bit follows, and then one stop bit. Once the stop bit is sampled, the word goes into a holding register that software reads through a read strobe.

Each completed frame reports three error conditions: a parity mismatch, a stop bit found low, and a frame that arrives while the previous word is still unread. An interrupt output follows the holding-register-full condition, gated by its own enable. The receiver checks only one stop bit. If the sender uses two, the second one looks like idle line and does not slow down back-to-back frames. A separate receive enable stops the receiver and aborts any frame in progress.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `full`, `err_parity`, `err_frame`, `err_overrun` and `irq` are all 0.
- R2: A frame is a low start bit, then the data bits least significant bit first, then an optional parity bit, then a high stop bit, with 16 `tick` pulses per bit. In 8-bit mode (`len8`=1) a good frame puts all 8 data bits on `rd_data` and sets `full`.
- R3: In 7-bit mode (`len8`=0) only 7 data bits are received, and `rd_data[7]` reads 0.
- R4: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit must hold an even count of ones, and with `par_odd`=1 an odd count. A mismatch sets `err_parity` together with `full`.
- R5: A stop bit sampled low sets `err_frame`. The word is still stored.
- R6: If a frame completes while `full` is 1, `err_overrun` is set, and the older word stays on `rd_data` with the other flags unchanged.
- R7: A one-cycle `rd_stb` clears `full` and all three error flags.
- R8: `irq` is 1 exactly when `full` is 1 and `irq_en` is 1.
- R9: A low pulse on the line that is already high again at the mid-start-bit sample (8 ticks after detection) is rejected, and no word is stored.
- R10: While `rx_en` is 0, line activity is ignored: no word is stored and no flag changes.
- R11: Only one stop bit is checked. A frame sent with two stop bits and followed at once by another frame is received, and so is the frame after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | Read strobe for the holding register |
| rd_data | output | DATA_W | Received word |
| full | output | 1 | Holding register holds an unread word |
| err_parity | output | 1 | Parity mismatch on the stored word |
| err_frame | output | 1 | Stop bit was low on the stored word |
| err_overrun | output | 1 | A frame was lost because the register was full |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is a frame sent with two stop bits whose second stop bit runs straight into the next start bit. The holding register must be drained within that window so the second frame can be checked as well. The stimulus handles this with a frame task that can pulse the read strobe in the first cycle of the new start bit, after the earlier word has been compared. Start glitches and low stop bits need care too, because a low stop bit makes the receiver see a false start that it must then reject. Every frame is therefore followed by enough idle line before the flags are compared.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic par;
    logic frm;
  } rx_err_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              enable,
  input  logic              len_full,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output rx_err_t           errs,
  output logic              busy
);

  localparam int TW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_W);
  localparam logic [TW-1:0] T_MID = TW'(OVERSAMPLE / 2 - 1);
  localparam logic [TW-1:0] T_END = TW'(OVERSAMPLE - 1);

  rx_state_e         st_q, st_n;
  logic [TW-1:0]     tc_q, tc_n;
  logic [BW-1:0]     bc_q, bc_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              acc_q, acc_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;
  logic              done_q, done_n;
  logic [BW-1:0]     last_bit;

  assign last_bit = len_full ? BW'(DATA_W - 1) : BW'(DATA_W - 2);

  // next-state logic
  always_comb begin
    st_n   = st_q;
    tc_n   = tc_q;
    bc_n   = bc_q;
    sh_n   = sh_q;
    acc_n  = acc_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    done_n = 1'b0;
    if (!enable) begin
      st_n = RX_IDLE;
      tc_n = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rx) begin
            st_n = RX_START;
            tc_n = '0;
          end
        end
        RX_START: begin
          if (tc_q == T_MID) begin
            tc_n   = '0;
            bc_n   = '0;
            acc_n  = 1'b0;
            perr_n = 1'b0;
            st_n   = rx ? RX_IDLE : RX_DATA;
          end else begin
            tc_n = tc_q + TW'(1);
          end
        end
        RX_DATA: begin
          if (tc_q == T_END) begin
            tc_n  = '0;
            sh_n  = {rx, sh_q[DATA_W-1:1]};
            acc_n = acc_q ^ rx;
            bc_n  = bc_q + BW'(1);
            if (bc_q == last_bit) st_n = par_en ? RX_PAR : RX_STOP;
          end else begin
            tc_n = tc_q + TW'(1);
          end
        end
        RX_PAR: begin
          if (tc_q == T_END) begin
            tc_n   = '0;
            perr_n = acc_q ^ rx ^ par_odd;
            st_n   = RX_STOP;
          end else begin
            tc_n = tc_q + TW'(1);
          end
        end
        RX_STOP: begin
          if (tc_q == T_END) begin
            tc_n   = '0;
            ferr_n = ~rx;
            done_n = 1'b1;
            st_n   = RX_IDLE;
          end else begin
            tc_n = tc_q + TW'(1);
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tc_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      tc_q   <= tc_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
      acc_q  <= acc_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      done_q <= done_n;
    end
  end

  assign done     = done_q;
  assign word     = len_full ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign errs.par = perr_q;
  assign errs.frm = ferr_q;
  assign busy     = (st_q != RX_IDLE);

endmodule

// File: rtl/srx_holding.sv
module srx_holding
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  rx_err_t           errs,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              perr,
  output logic              ferr,
  output logic              ovr
);

  logic [DATA_W-1:0] data_q, data_n;
  logic              full_q, full_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;
  logic              ovr_q, ovr_n;

  // next-state logic: a read in the same cycle frees the register first
  always_comb begin
    data_n = data_q;
    full_n = full_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    ovr_n  = ovr_q;
    if (rd) begin
      full_n = 1'b0;
      perr_n = 1'b0;
      ferr_n = 1'b0;
      ovr_n  = 1'b0;
    end
    if (load) begin
      if (full_q && !rd) begin
        ovr_n = 1'b1;
      end else begin
        data_n = word;
        full_n = 1'b1;
        perr_n = errs.par;
        ferr_n = errs.frm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      ovr_q  <= ovr_n;
    end
  end

  assign data = data_q;
  assign full = full_q;
  assign perr = perr_q;
  assign ferr = ferr_q;
  assign ovr  = ovr_q;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              len8,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq
);

  logic              rx_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_word;
  rx_err_t           frm_errs;
  logic              fsm_busy;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_in),
    .dout (rx_s)
  );

  srx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rx      (rx_s),
    .enable  (rx_en),
    .len_full(len8),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (frm_done),
    .word    (frm_word),
    .errs    (frm_errs),
    .busy    (fsm_busy)
  );

  srx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frm_done),
    .word (frm_word),
    .errs (frm_errs),
    .rd   (rd_stb),
    .data (rd_data),
    .full (full),
    .perr (err_parity),
    .ferr (err_frame),
    .ovr  (err_overrun)
  );

  assign irq = full & irq_en;

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              irq_en,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              full,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              irq,
  input logic              frm_done,
  input logic              fsm_busy
);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full && irq_en));

  // R4
  par_flag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> full);

  // R5
  frm_flag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> full);

  // R6
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(full));

  // R6
  hold_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_stb) |=> $stable(rd_data));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !frm_done) |=> (!full && !err_overrun));

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !fsm_busy);

endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .irq_en     (irq_en),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .full       (full),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_overrun(err_overrun),
  .irq        (irq),
  .frm_done   (frm_done),
  .fsm_busy   (fsm_busy)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

  localparam int BITC = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rx_in = 1'b1;
  logic       rx_en = 1'b1;
  logic       len8 = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       full, err_parity, err_frame, err_overrun, irq;
  logic [1:0] div_q = 2'd0;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [7:0] e_data = 8'h00;
  bit e_full = 0, e_perr = 0, e_ferr = 0, e_ovr = 0;

  always #10 clk = ~clk;

  always @(posedge clk) div_q <= div_q + 2'd1;
  assign tick = (div_q == 2'd3);

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .rx_en(rx_en),
    .len8(len8), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .rd_stb(rd_stb), .rd_data(rd_data), .full(full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input bit l8, input bit odd);
    logic [7:0] m;
    m = l8 ? d : {1'b0, d[6:0]};
    return (^m) ^ odd;
  endfunction

  task automatic idle(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rx_in = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    e_full = 0; e_perr = 0; e_ferr = 0; e_ovr = 0;
  endtask

  // sends one frame with the current mode inputs and updates the model
  task automatic send_frame(input logic [7:0] d, input bit badp, input bit bads,
                            input int nstop, input bit rd_first);
    int nb;
    nb = len8 ? 8 : 7;
    rx_in = 1'b0;
    if (rd_first) begin
      do_read();
      repeat (BITC - 1) @(negedge clk);
    end else begin
      repeat (BITC) @(negedge clk);
    end
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_en) drive_bit(par_bit(d, len8, par_odd) ^ badp);
    drive_bit(~bads);
    for (int i = 1; i < nstop; i++) drive_bit(1'b1);
    rx_in = 1'b1;
    if (rx_en) begin
      if (e_full) e_ovr = 1;
      else begin
        e_full = 1;
        e_data = len8 ? d : {1'b0, d[6:0]};
        e_perr = par_en && badp;
        e_ferr = bads;
      end
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " full"}, full, e_full);
    if (e_full) chk({tag, " data R2"}, rd_data, e_data);
    chk({tag, " parity R4"}, err_parity, e_perr);
    chk({tag, " frame R5"}, err_frame, e_ferr);
    chk({tag, " overrun R6"}, err_overrun, e_ovr);
    chk({tag, " irq R8"}, irq, e_full & irq_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 perr", err_parity, 0);
    chk("R1 ferr", err_frame, 0);
    chk("R1 ovr", err_overrun, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    idle(40);

    // R2 8-bit, no parity
    irq_en = 1;
    send_frame(8'hA5, 0, 0, 1, 0); idle(96);
    check_all("R2 8bit");

    // R7 read clears
    do_read(); idle(4);
    chk("R7 full cleared", full, 0);
    chk("R8 irq low after read", irq, 0);

    // R3 7-bit mode
    len8 = 0;
    send_frame(8'hD3, 0, 0, 1, 0); idle(96);
    chk("R3 7bit data", rd_data, 8'h53);
    check_all("R3 7bit");
    do_read(); len8 = 1;

    // R4 even correct, odd wrong
    par_en = 1; par_odd = 0;
    send_frame(8'h3C, 0, 0, 1, 0); idle(96);
    check_all("R4 even good");
    do_read(); par_odd = 1;
    send_frame(8'h81, 1, 0, 1, 0); idle(96);
    chk("R4 odd bad flag", err_parity, 1);
    check_all("R4 odd bad");
    do_read(); par_en = 0;

    // R5 low stop bit
    send_frame(8'h66, 0, 1, 1, 0); idle(96);
    chk("R5 frame flag", err_frame, 1);
    check_all("R5");

    // R6 overrun keeps older word
    send_frame(8'h19, 0, 0, 1, 0); idle(96);
    chk("R6 overrun flag", err_overrun, 1);
    chk("R6 old word kept", rd_data, 8'h66);
    check_all("R6");
    do_read(); idle(4);
    chk("R7 flags cleared", {err_parity, err_frame, err_overrun}, 3'b000);

    // R8 irq gated
    irq_en = 0;
    send_frame(8'h77, 0, 0, 1, 0); idle(96);
    chk("R8 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R8 irq enabled", irq, 1);
    do_read();

    // R9 start glitch rejected
    rx_in = 1'b0; repeat (12) @(negedge clk);
    idle(200);
    chk("R9 glitch no word", full, 0);
    send_frame(8'hC2, 0, 0, 1, 0); idle(96);
    check_all("R9 after glitch");
    do_read();

    // R10 receiver disabled
    rx_en = 0;
    send_frame(8'h5E, 0, 0, 1, 0); idle(96);
    chk("R10 disabled no word", full, 0);
    chk("R10 disabled no flags", {err_parity, err_frame, err_overrun}, 3'b000);
    rx_en = 1; idle(8);

    // R11 two stop bits back-to-back
    send_frame(8'h2B, 0, 0, 2, 0);
    chk("R11 first word", rd_data, 8'h2B);
    chk("R11 first full", full, 1);
    send_frame(8'hE4, 0, 0, 2, 1);
    send_frame(8'h9D, 0, 0, 1, 0); idle(96);
    chk("R11 second frame overrun", err_overrun, 1);
    chk("R11 second word", rd_data, 8'hE4);
    check_all("R11");
    do_read();

    // constrained random frames
    for (int i = 0; i < 36; i++) begin
      a       = 8'($urandom);
      len8    = 1'($urandom % 2);
      par_en  = 1'($urandom % 2);
      par_odd = 1'($urandom % 2);
      irq_en  = 1'($urandom % 2);
      if ($urandom % 4 != 0) do_read();
      send_frame(a, ($urandom % 5) == 0, ($urandom % 6) == 0, 1 + ($urandom % 2), 0);
      idle(96);
      check_all("R2 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule